// File: doc/BRIEF.md
# Status Register and Banked Register Files

This block keeps the processor status word and the floating-point status/control word, plus the two register files whose visible half each of those words selects. The integer file has eight low registers with a shadow set of eight. The floating-point file has two banks of sixteen registers each. The execution pipeline reads and writes registers through indexed ports that always address the currently visible bank.

The status word and the floating-point control word are each written through their own port and stored through a fixed writable-bits mask. The four condition flags (T, S, Q, M) live in separate flops. An ALU can update them through a dedicated port, and they are merged back into their bit positions whenever the status word is read.

A bank exchange does not copy any data. Each file is addressed through a select bit, so an exchange takes effect in the cycle after the write that causes it. The block also drives a three-bit mode word for the decoder. It raises a one-cycle notice toward the interrupt controller after every status write, because the interrupt mask may have changed.

Top module: `statusBankCore`

## Requirements
- R1: After reset the status word reads 0x700000F0, the control word reads 0x00040001, the mode word is 3'b100, `maskChanged` is low, and every visible register reads zero.
- R2: A status write stores the written value ANDed with 0x700083F3. From the next cycle, reading the status word returns exactly that value.
- R3: The flags T (bit 0), S (bit 1), Q (bit 8) and M (bit 9) are held separately. `flagWrData` carries them as {M,Q,S,T} in bits 3..0, and a flag write shows in those status bit positions from the next cycle. When a flag write and a status write happen in the same cycle, the status write wins.
- R4: The visible integer bank is MD (bit 30) AND RB (bit 29). Registers R0..R7 trade places with their shadows only when a status write changes that product. A write that changes MD while RB stays 0 leaves the visible contents as they were.
- R5: An integer register write goes to the currently visible bank and reads back from the next cycle. Each bank keeps its own contents across repeated exchanges.
- R6: A control-word write stores the written value ANDed with 0x003FFFFF.
- R7: When a control-word write changes FR (bit 21), the two sixteen-entry floating-point banks trade places. A control-word write that leaves FR unchanged does not move the visible contents.
- R8: The mode word is {MD, SZ (control bit 20), PR (control bit 19)}. It reflects each status or control write from the next cycle.
- R9: `maskChanged` is high for exactly the one cycle that follows each status write, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srWrEn | input | 1 | Status word write strobe |
| srWrData | input | 32 | Status word write value |
| srRdData | output | 32 | Status word with flags merged in |
| flagWrEn | input | 1 | Condition flag write strobe |
| flagWrData | input | 4 | New flags {M,Q,S,T} |
| fpscrWrEn | input | 1 | Control word write strobe |
| fpscrWrData | input | 32 | Control word write value |
| fpscrRdData | output | 32 | Stored control word |
| gprWrEn | input | 1 | Integer register write strobe |
| gprWrIdx | input | 3 | Integer register write index |
| gprWrData | input | 32 | Integer register write value |
| gprRdIdx | input | 3 | Integer register read index |
| gprRdData | output | 32 | Integer register read value |
| fprWrEn | input | 1 | Float register write strobe |
| fprWrIdx | input | 4 | Float register write index |
| fprWrData | input | 32 | Float register write value |
| fprRdIdx | input | 4 | Float register read index |
| fprRdData | output | 32 | Float register read value |
| modeWord | output | 3 | {MD, SZ, PR} |
| maskChanged | output | 1 | One-cycle notice after a status write |

## Verification
The bench builds the block with its default parameters: a 32-bit word, eight banked integer registers and sixteen float registers per bank. It can therefore walk every writable and read-only bit of both masks. It also reaches each index in both halves of the physical storage. With these sizes the bench can place a value in one bank, flip the select, and see the other bank's value appear at the same index. It can then flip back and see the first value again. It also covers the case where only one of the two select bits moves, and the case where a write leaves FR unchanged.

// File: rtl/statusBankPkg.sv
package statusBankPkg;
  localparam int SR_T_POS  = 0;
  localparam int SR_S_POS  = 1;
  localparam int SR_Q_POS  = 8;
  localparam int SR_M_POS  = 9;
  localparam int SR_FD_POS = 15;
  localparam int SR_BL_POS = 28;
  localparam int SR_RB_POS = 29;
  localparam int SR_MD_POS = 30;
  localparam int FP_PR_POS = 19;
  localparam int FP_SZ_POS = 20;
  localparam int FP_FR_POS = 21;

  typedef struct packed {
    logic gprSel;
    logic fprSel;
    logic gprWe;
    logic fprWe;
  } bankStrobes_t;
endpackage

// File: rtl/statusBankCtrl.sv
module statusBankCtrl
  import statusBankPkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] SR_WMASK    = 32'h700083F3,
  parameter logic [31:0] FPSCR_WMASK = 32'h003FFFFF,
  parameter logic [31:0] SR_INIT     = 32'h700000F0,
  parameter logic [31:0] FPSCR_INIT  = 32'h00040001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              srWrEn,
  input  logic [DATA_W-1:0] srWrData,
  input  logic              flagWrEn,
  input  logic [3:0]        flagWrData,
  input  logic              fpscrWrEn,
  input  logic [DATA_W-1:0] fpscrWrData,
  input  logic              gprWrEn,
  input  logic              fprWrEn,
  output bankStrobes_t      strobes,
  output logic [DATA_W-1:0] srRdData,
  output logic [DATA_W-1:0] fpscrRdData,
  output logic [2:0]        modeWord,
  output logic              maskChanged
);
  localparam logic [DATA_W-1:0] FLAG_POSITIONS =
    DATA_W'((32'd1 << SR_T_POS) | (32'd1 << SR_S_POS) |
            (32'd1 << SR_Q_POS) | (32'd1 << SR_M_POS));
  localparam logic [DATA_W-1:0] SR_MASK_W = DATA_W'(SR_WMASK);
  localparam logic [DATA_W-1:0] FP_MASK_W = DATA_W'(FPSCR_WMASK);
  localparam logic [DATA_W-1:0] SR_INIT_W = DATA_W'(SR_INIT & SR_WMASK);
  localparam logic [DATA_W-1:0] FP_INIT_W = DATA_W'(FPSCR_INIT & FPSCR_WMASK);

  logic [DATA_W-1:0] srCore;
  logic [DATA_W-1:0] fpscrReg;
  logic [3:0]        flagBits;   // {M,Q,S,T}
  logic              notePulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srCore   <= SR_INIT_W;
      flagBits <= {SR_INIT_W[SR_M_POS], SR_INIT_W[SR_Q_POS],
                   SR_INIT_W[SR_S_POS], SR_INIT_W[SR_T_POS]};
    end else if (srWrEn) begin
      srCore   <= srWrData & SR_MASK_W;
      flagBits <= {srWrData[SR_M_POS], srWrData[SR_Q_POS],
                   srWrData[SR_S_POS], srWrData[SR_T_POS]};
    end else if (flagWrEn) begin
      flagBits <= flagWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          fpscrReg <= FP_INIT_W;
    else if (fpscrWrEn) fpscrReg <= fpscrWrData & FP_MASK_W;
  end

  always_ff @(posedge clk) begin
    if (!rstN) notePulse <= 1'b0;
    else       notePulse <= srWrEn;
  end

  always_comb begin
    srRdData = srCore & ~FLAG_POSITIONS;
    srRdData[SR_T_POS] = flagBits[0];
    srRdData[SR_S_POS] = flagBits[1];
    srRdData[SR_Q_POS] = flagBits[2];
    srRdData[SR_M_POS] = flagBits[3];
  end

  assign fpscrRdData    = fpscrReg;
  assign modeWord       = {srCore[SR_MD_POS], fpscrReg[FP_SZ_POS], fpscrReg[FP_PR_POS]};
  assign maskChanged    = notePulse;
  assign strobes.gprSel = srCore[SR_MD_POS] & srCore[SR_RB_POS];
  assign strobes.fprSel = fpscrReg[FP_FR_POS];
  assign strobes.gprWe  = gprWrEn;
  assign strobes.fprWe  = fprWrEn;
endmodule

// File: rtl/statusBankData.sv
module statusBankData
  import statusBankPkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int GPR_BANKED   = 8,
  parameter int FPR_PER_BANK = 16,
  localparam int GPR_IDX_W   = $clog2(GPR_BANKED),
  localparam int FPR_IDX_W   = $clog2(FPR_PER_BANK)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bankStrobes_t         strobes,
  input  logic [GPR_IDX_W-1:0] gprWrIdx,
  input  logic [DATA_W-1:0]    gprWrData,
  input  logic [GPR_IDX_W-1:0] gprRdIdx,
  output logic [DATA_W-1:0]    gprRdData,
  input  logic [FPR_IDX_W-1:0] fprWrIdx,
  input  logic [DATA_W-1:0]    fprWrData,
  input  logic [FPR_IDX_W-1:0] fprRdIdx,
  output logic [DATA_W-1:0]    fprRdData
);
  localparam int GPR_PHYS = 2 * GPR_BANKED;
  localparam int FPR_PHYS = 2 * FPR_PER_BANK;

  logic [DATA_W-1:0] gprStore [GPR_PHYS];
  logic [DATA_W-1:0] fprStore [FPR_PHYS];

  logic [GPR_IDX_W:0] gprWrPhys, gprRdPhys;
  logic [FPR_IDX_W:0] fprWrPhys, fprRdPhys;

  assign gprWrPhys = {strobes.gprSel, gprWrIdx};
  assign gprRdPhys = {strobes.gprSel, gprRdIdx};
  assign fprWrPhys = {strobes.fprSel, fprWrIdx};
  assign fprRdPhys = {strobes.fprSel, fprRdIdx};

  for (genvar g = 0; g < GPR_PHYS; g++) begin : gGpr
    always_ff @(posedge clk) begin
      if (!rstN)
        gprStore[g] <= '0;
      else if (strobes.gprWe && gprWrPhys == (GPR_IDX_W+1)'(g))
        gprStore[g] <= gprWrData;
    end
  end

  for (genvar f = 0; f < FPR_PHYS; f++) begin : gFpr
    always_ff @(posedge clk) begin
      if (!rstN)
        fprStore[f] <= '0;
      else if (strobes.fprWe && fprWrPhys == (FPR_IDX_W+1)'(f))
        fprStore[f] <= fprWrData;
    end
  end

  assign gprRdData = gprStore[gprRdPhys];
  assign fprRdData = fprStore[fprRdPhys];
endmodule

// File: rtl/statusBankCore.sv
module statusBankCore
  import statusBankPkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int GPR_BANKED   = 8,
  parameter int FPR_PER_BANK = 16,
  localparam int GPR_IDX_W   = $clog2(GPR_BANKED),
  localparam int FPR_IDX_W   = $clog2(FPR_PER_BANK)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 srWrEn,
  input  logic [DATA_W-1:0]    srWrData,
  output logic [DATA_W-1:0]    srRdData,
  input  logic                 flagWrEn,
  input  logic [3:0]           flagWrData,
  input  logic                 fpscrWrEn,
  input  logic [DATA_W-1:0]    fpscrWrData,
  output logic [DATA_W-1:0]    fpscrRdData,
  input  logic                 gprWrEn,
  input  logic [GPR_IDX_W-1:0] gprWrIdx,
  input  logic [DATA_W-1:0]    gprWrData,
  input  logic [GPR_IDX_W-1:0] gprRdIdx,
  output logic [DATA_W-1:0]    gprRdData,
  input  logic                 fprWrEn,
  input  logic [FPR_IDX_W-1:0] fprWrIdx,
  input  logic [DATA_W-1:0]    fprWrData,
  input  logic [FPR_IDX_W-1:0] fprRdIdx,
  output logic [DATA_W-1:0]    fprRdData,
  output logic [2:0]           modeWord,
  output logic                 maskChanged
);
  bankStrobes_t strobes;

  statusBankCtrl #(.DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .srWrEn(srWrEn), .srWrData(srWrData),
    .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .fpscrWrEn(fpscrWrEn), .fpscrWrData(fpscrWrData),
    .gprWrEn(gprWrEn), .fprWrEn(fprWrEn),
    .strobes(strobes),
    .srRdData(srRdData), .fpscrRdData(fpscrRdData),
    .modeWord(modeWord), .maskChanged(maskChanged)
  );

  statusBankData #(
    .DATA_W(DATA_W), .GPR_BANKED(GPR_BANKED), .FPR_PER_BANK(FPR_PER_BANK)
  ) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .gprWrIdx(gprWrIdx), .gprWrData(gprWrData),
    .gprRdIdx(gprRdIdx), .gprRdData(gprRdData),
    .fprWrIdx(fprWrIdx), .fprWrData(fprWrData),
    .fprRdIdx(fprRdIdx), .fprRdData(fprRdData)
  );
endmodule

// File: rtl/statusBankChecker.sv
module statusBankChecker #(
  parameter int          DATA_W      = 32,
  parameter int          GPR_IDX_W   = 3,
  parameter int          FPR_IDX_W   = 4,
  parameter logic [31:0] SR_WMASK    = 32'h700083F3,
  parameter logic [31:0] FPSCR_WMASK = 32'h003FFFFF
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 srWrEn,
  input logic [DATA_W-1:0]    srWrData,
  input logic [DATA_W-1:0]    srRdData,
  input logic                 flagWrEn,
  input logic [3:0]           flagWrData,
  input logic                 fpscrWrEn,
  input logic [DATA_W-1:0]    fpscrWrData,
  input logic [DATA_W-1:0]    fpscrRdData,
  input logic                 gprWrEn,
  input logic [GPR_IDX_W-1:0] gprRdIdx,
  input logic [DATA_W-1:0]    gprRdData,
  input logic                 fprWrEn,
  input logic [FPR_IDX_W-1:0] fprRdIdx,
  input logic [DATA_W-1:0]    fprRdData,
  input logic [2:0]           modeWord,
  input logic                 maskChanged
);
  p_sr_masked_r2: assert property (@(posedge clk) disable iff (!rstN)
    srWrEn |=> srRdData == ($past(srWrData) & DATA_W'(SR_WMASK)));

  p_sr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!srWrEn && !flagWrEn) |=> $stable(srRdData));

  p_flag_merge_r3: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrEn && !srWrEn) |=>
      {srRdData[9], srRdData[8], srRdData[1], srRdData[0]} == $past(flagWrData));

  p_gpr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!srWrEn && !gprWrEn) |=> ($stable(gprRdIdx) -> $stable(gprRdData)));

  p_fpscr_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    fpscrWrEn |=> fpscrRdData == ($past(fpscrWrData) & DATA_W'(FPSCR_WMASK)));

  p_fpr_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!fpscrWrEn && !fprWrEn) |=> ($stable(fprRdIdx) -> $stable(fprRdData)));

  p_mode_track_r8: assert property (@(posedge clk) disable iff (!rstN)
    modeWord == {srRdData[30], fpscrRdData[20], fpscrRdData[19]});

  p_notice_on_r9: assert property (@(posedge clk) disable iff (!rstN)
    srWrEn |=> maskChanged);

  p_notice_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !srWrEn |=> !maskChanged);
endmodule

bind statusBankCore statusBankChecker #(
  .DATA_W(DATA_W), .GPR_IDX_W(GPR_IDX_W), .FPR_IDX_W(FPR_IDX_W)
) uChk (
  .clk(clk), .rstN(rstN),
  .srWrEn(srWrEn), .srWrData(srWrData), .srRdData(srRdData),
  .flagWrEn(flagWrEn), .flagWrData(flagWrData),
  .fpscrWrEn(fpscrWrEn), .fpscrWrData(fpscrWrData), .fpscrRdData(fpscrRdData),
  .gprWrEn(gprWrEn), .gprRdIdx(gprRdIdx), .gprRdData(gprRdData),
  .fprWrEn(fprWrEn), .fprRdIdx(fprRdIdx), .fprRdData(fprRdData),
  .modeWord(modeWord), .maskChanged(maskChanged)
);

// File: tb/sim_statusBankCore.sv
`timescale 1ns/1ps
module sim_statusBankCore;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        srWrEn = 1'b0;
  logic [31:0] srWrData = '0;
  logic [31:0] srRdData;
  logic        flagWrEn = 1'b0;
  logic [3:0]  flagWrData = '0;
  logic        fpscrWrEn = 1'b0;
  logic [31:0] fpscrWrData = '0;
  logic [31:0] fpscrRdData;
  logic        gprWrEn = 1'b0;
  logic [2:0]  gprWrIdx = '0;
  logic [31:0] gprWrData = '0;
  logic [2:0]  gprRdIdx = '0;
  logic [31:0] gprRdData;
  logic        fprWrEn = 1'b0;
  logic [3:0]  fprWrIdx = '0;
  logic [31:0] fprWrData = '0;
  logic [3:0]  fprRdIdx = '0;
  logic [31:0] fprRdData;
  logic [2:0]  modeWord;
  logic        maskChanged;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  statusBankCore u0 (.*);

  // {written value, expected read-back}
  localparam logic [63:0] SR_VECS [6] = '{
    {32'hFFFFFFFF, 32'h700083F3},
    {32'h00000000, 32'h00000000},
    {32'h12345678, 32'h10000270},
    {32'h80000301, 32'h00000301},
    {32'h400000F2, 32'h400000F2},
    {32'h0FFF7C0C, 32'h00000000}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic writeSr(logic [31:0] d);
    srWrEn = 1'b1; srWrData = d;
    tick();
    srWrEn = 1'b0;
  endtask

  task automatic writeFpscr(logic [31:0] d);
    fpscrWrEn = 1'b1; fpscrWrData = d;
    tick();
    fpscrWrEn = 1'b0;
  endtask

  task automatic writeGpr(logic [2:0] i, logic [31:0] d);
    gprWrEn = 1'b1; gprWrIdx = i; gprWrData = d;
    tick();
    gprWrEn = 1'b0;
  endtask

  task automatic writeFpr(logic [3:0] i, logic [31:0] d);
    fprWrEn = 1'b1; fprWrIdx = i; fprWrData = d;
    tick();
    fprWrEn = 1'b0;
  endtask

  task automatic readGpr(string req, logic [2:0] i, logic [31:0] exp);
    gprRdIdx = i; #1;
    check(req, gprRdData, exp);
  endtask

  task automatic readFpr(string req, logic [3:0] i, logic [31:0] exp);
    fprRdIdx = i; #1;
    check(req, fprRdData, exp);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 sr", srRdData, 32'h700000F0);
    check("R1 fpscr", fpscrRdData, 32'h00040001);
    check("R1 mode", {29'd0, modeWord}, 32'd4);
    check("R1 notice", {31'd0, maskChanged}, 32'd0);
    readGpr("R1 gpr", 3'd5, 32'd0);
    readFpr("R1 fpr", 4'd9, 32'd0);

    // R2 vector walk, R9 notice after each
    foreach (SR_VECS[k]) begin
      writeSr(SR_VECS[k][63:32]);
      check("R2 masked sr", srRdData, SR_VECS[k][31:0]);
      check("R9 notice high", {31'd0, maskChanged}, 32'd1);
      tick();
      check("R9 notice low", {31'd0, maskChanged}, 32'd0);
    end

    // R3 flags
    writeSr(32'h00000000);
    flagWrEn = 1'b1; flagWrData = 4'b1111; tick(); flagWrEn = 1'b0;
    check("R3 all flags", srRdData, 32'h00000303);
    flagWrEn = 1'b1; flagWrData = 4'b0101; tick(); flagWrEn = 1'b0;
    check("R3 Q and T", srRdData, 32'h00000101);
    check("R9 no notice on flag write", {31'd0, maskChanged}, 32'd0);
    flagWrEn = 1'b1; flagWrData = 4'b1111;
    srWrEn = 1'b1; srWrData = 32'h00000002;
    tick();
    flagWrEn = 1'b0; srWrEn = 1'b0;
    check("R3 sr write wins", srRdData, 32'h00000002);

    // R4/R5 integer banks
    writeSr(32'h60000000);               // select 1
    writeGpr(3'd3, 32'h000000A1);
    readGpr("R5 write visible", 3'd3, 32'h000000A1);
    writeSr(32'h00000000);               // select 0
    readGpr("R4 shadow shown", 3'd3, 32'h00000000);
    writeGpr(3'd3, 32'h000000B2);
    writeGpr(3'd7, 32'h000000C3);
    writeSr(32'h40000000);               // MD only: no exchange
    readGpr("R4 MD alone no swap", 3'd3, 32'h000000B2);
    check("R8 mode MD", {29'd0, modeWord}, 32'd4);
    writeSr(32'h20000000);               // RB only: no exchange
    readGpr("R4 RB alone no swap", 3'd7, 32'h000000C3);
    writeSr(32'h60000000);               // exchange
    readGpr("R4 swap back", 3'd3, 32'h000000A1);
    readGpr("R5 other idx banked", 3'd7, 32'h00000000);
    writeSr(32'h70000000);               // product stays 1
    readGpr("R4 BL change no swap", 3'd3, 32'h000000A1);
    writeSr(32'h00000000);
    readGpr("R5 bank kept", 3'd7, 32'h000000C3);

    // R6/R7/R8 float banks and control word
    writeFpr(4'd5, 32'h00000011);
    writeFpr(4'd15, 32'h000000FF);
    writeFpscr(32'h00200000);            // FR 0->1
    readFpr("R7 swap on FR", 4'd5, 32'h00000000);
    writeFpr(4'd5, 32'h00000022);
    writeFpscr(32'h00280000);            // FR stays 1, PR set
    readFpr("R7 no swap same FR", 4'd5, 32'h00000022);
    check("R8 mode PR", {29'd0, modeWord}, 32'd1);
    writeFpscr(32'h00000000);            // FR 1->0
    readFpr("R7 swap back", 4'd5, 32'h00000011);
    readFpr("R7 last index", 4'd15, 32'h000000FF);
    writeFpscr(32'hFFFFFFFF);
    check("R6 masked fpscr", fpscrRdData, 32'h003FFFFF);
    check("R8 mode SZ PR", {29'd0, modeWord}, 32'd3);
    readFpr("R7 full write swaps", 4'd5, 32'h00000022);
    writeSr(32'h40000000);
    check("R8 mode all", {29'd0, modeWord}, 32'd7);

    done = 1'b1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      checkCnt++;
      $display("FAIL watchdog actual=running expected=done");
      finishRun();
    end
  end
endmodule